// File: doc/BRIEF.md
# Matrix Keyboard Scanner and Key-Code Queue

The block scans an 8 x 8 key matrix. A free-running scan counter presents the current row on four encoded scan outputs, which an external decoder can expand into row strobes. The keyboard answers on eight return inputs, one per column. Inside each row dwell the block examines one column per clock, so every key is visited once in each 64-cycle scan pass. A key that reads closed on two consecutive passes is accepted once. Its code is then queued in an eight-entry FIFO, together with the row, the column and the levels of the shift and control inputs.

A processor reaches the block through a byte-wide port with one address bit. Address 0 reads data: it returns the oldest queued code and pops it. Address 1 reads status or writes the mode byte. An interrupt output stays high while at least one code is waiting. The rollover policy can be set by software. In lockout mode, a new key is taken only while no other key is held, so the first key wins. In rollover mode, every closed key is queued in scan order.

Top module: `kbd_scan_encoder`

## Requirements
- R1: `scan_o` carries the row index (0..7) with bit 3 held at 0. Each row is held for 8 clocks and then advances by one, wrapping from 7 to 0. After reset the row is 0.
- R2: A key (`ret_i[c]` high while row r is scanned) is accepted only when it reads closed on two consecutive examinations, one 64-cycle pass apart. It is then queued exactly once.
- R3: An accepted key that stays closed is not queued again. It must read open at one examination before it can be accepted anew.
- R4: A queued code is {ctrl_i, shift_i, row[2:0], col[2:0]} (bit 7 down to bit 0). The shift and control levels are taken in the cycle of acceptance.
- R5: Lockout mode (mode bit 0 = 0, the reset value): a key is accepted only while no other key is held. A key blocked this way is accepted once the held key reads open, provided it is still closed.
- R6: Rollover mode (mode bit 0 = 1): every debounced key is queued, in the order the scan reaches it.
- R7: The FIFO holds 8 codes and returns them in arrival order. A data read (`cs_i & rd_i`, `addr_i` = 0) returns the oldest code on `rdata_o` and pops it. On an empty FIFO the read returns 0 and changes nothing.
- R8: With `addr_i` = 1, `rdata_o` shows status: bit 7 overflow, bit 6 mode, bits 3:0 entry count, other bits 0. A status read (`cs_i & rd_i`) clears overflow. A write (`cs_i & wr_i`, `addr_i` = 1) loads the mode from `wdata_i[0]`.
- R9: A key accepted while the FIFO already holds 8 codes is dropped, and overflow is set. A drop in the same cycle as a status read still leaves overflow set.
- R10: `irq_o` is high exactly when the FIFO count is non-zero.
- R11: Reset leaves the row at 0, the FIFO empty, `irq_o` low, overflow clear and lockout mode selected.
- R12: With `cs_i` low, `rd_i` and `wr_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ret_i | input | 8 | Column return lines, high = closed |
| shift_i | input | 1 | Shift level packed into codes |
| ctrl_i | input | 1 | Control level packed into codes |
| scan_o | output | 4 | Encoded scan row |
| cs_i | input | 1 | Port select |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 1 | 0 = data, 1 = status/mode |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from `addr_i` |
| irq_o | output | 1 | Data waiting |

## Verification
Per-key debounce state that is wrong shows up one or two scan passes later, up to 128 cycles. It appears as a missing code, a duplicate code or a wrongly ordered code in the queue, and as an early or late rise of `irq_o`. A wrong FIFO pointer or count shows at the next data or status read as a wrong code or a wrong count. A wrong interrupt shows on the very next clock, and a scan counter fault is seen within one row dwell. The bench model is therefore compared on every clock, and directed reads pin down the codes and counts at chosen points.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int unsigned ROW_W  = 3;
  localparam int unsigned COL_W  = 3;
  localparam int unsigned SCAN_W = 4;
  localparam int unsigned CODE_W = ROW_W + COL_W + 2;

  typedef struct packed {
    logic             ctrl;
    logic             shift;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
  } key_code_t;
endpackage

// File: rtl/kbd_scan_ctr.sv
module kbd_scan_ctr #(
  parameter int unsigned ROW_W = 3,
  parameter int unsigned COL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o
);
  localparam logic [COL_W-1:0] COL_LAST = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_o <= '0;
      col_o <= '0;
    end else begin
      col_o <= col_o + 1'b1;
      if (col_o == COL_LAST) row_o <= row_o + 1'b1;
    end
  end

  AST_ROW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_o != COL_LAST) |=> $stable(row_o)); // R1
  AST_ROW_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_o == COL_LAST) |=> (row_o == ROW_W'($past(row_o) + 1'b1))); // R1
endmodule

// File: rtl/kbd_key_track.sv
module kbd_key_track #(
  parameter int unsigned ROW_W = 3,
  parameter int unsigned COL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             closed_i,
  input  logic             rollover_i,
  output logic             accept_o
);
  localparam int unsigned IDX_W  = ROW_W + COL_W;
  localparam int unsigned N_KEYS = 1 << IDX_W;

  logic [N_KEYS-1:0] seen_q;  // closed at previous pass
  logic [N_KEYS-1:0] held_q;  // accepted, awaiting release
  logic [IDX_W-1:0]  idx;

  assign idx = {row_i, col_i};

  always_comb begin
    accept_o = closed_i && seen_q[idx] && !held_q[idx]
               && (rollover_i || (held_q == '0));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= '0;
      held_q <= '0;
    end else if (!closed_i) begin
      seen_q[idx] <= 1'b0;
      held_q[idx] <= 1'b0;
    end else begin
      seen_q[idx] <= 1'b1;
      if (accept_o) held_q[idx] <= 1'b1;
    end
  end

  AST_HELD_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && closed_i) |=> (held_q != '0)); // R3
endmodule

// File: rtl/kbd_code_fifo.sv
module kbd_code_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign rdata_o = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH)); // R7
  AST_POP_SHRINKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1))); // R7
endmodule

// File: rtl/kbd_scan_encoder.sv
module kbd_scan_encoder #(
  parameter int unsigned FIFO_DEPTH = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [(1<<kbd_pkg::COL_W)-1:0] ret_i,
  input  logic                       shift_i,
  input  logic                       ctrl_i,
  output logic [kbd_pkg::SCAN_W-1:0] scan_o,
  input  logic                       cs_i,
  input  logic                       rd_i,
  input  logic                       wr_i,
  input  logic                       addr_i,
  input  logic [7:0]                 wdata_i,
  output logic [7:0]                 rdata_o,
  output logic                       irq_o
);
  import kbd_pkg::*;
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic             accept, fifo_push, fifo_pop, full, empty;
  logic             mode_q, ovf_q;
  logic [CNT_W-1:0] count;
  logic [CODE_W-1:0] head;
  key_code_t        code;
  logic [7:0]       status;

  kbd_scan_ctr #(.ROW_W(ROW_W), .COL_W(COL_W)) u_scan (
    .clk_i(clk_i), .rst_ni(rst_ni), .row_o(row), .col_o(col));

  kbd_key_track #(.ROW_W(ROW_W), .COL_W(COL_W)) u_track (
    .clk_i(clk_i), .rst_ni(rst_ni), .row_i(row), .col_i(col),
    .closed_i(ret_i[col]), .rollover_i(mode_q), .accept_o(accept));

  assign code      = '{ctrl: ctrl_i, shift: shift_i, row: row, col: col};
  assign fifo_push = accept && !full;  // full at acceptance: code dropped
  assign fifo_pop  = cs_i && rd_i && !addr_i && !empty;

  kbd_code_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(CODE_W)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(fifo_push), .pop_i(fifo_pop),
    .wdata_i(code), .rdata_o(head), .count_o(count), .full_o(full),
    .empty_o(empty));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (cs_i && wr_i && addr_i) mode_q <= wdata_i[0];
      if (accept && full)              ovf_q <= 1'b1;
      else if (cs_i && rd_i && addr_i) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    status = '0;
    status[CNT_W-1:0] = count;
    status[6] = mode_q;
    status[7] = ovf_q;
  end

  assign rdata_o = addr_i ? status : (empty ? 8'h00 : 8'(head));
  assign irq_o   = !empty;
  assign scan_o  = SCAN_W'(row);

  AST_DROP_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && full) |=> ovf_q); // R9
  AST_IRQ_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_pop && !fifo_push && count == CNT_W'(1)) |=> !irq_o); // R10
  AST_IDLE_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_i && !accept) |=> ($stable(count) && $stable(mode_q))); // R12
endmodule

// File: tb/kbd_scan_encoder_test.sv
`timescale 1ns/1ps
module kbd_scan_encoder_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] ret;
  logic       shift = 1'b0, ctrl = 1'b0;
  logic [3:0] scan_o;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata_o;
  logic       irq_o;
  logic [7:0] pressed [8];

  int checks = 0, fails = 0;
  int slot = 0;
  bit m_seen [64];
  bit m_held [64];
  bit m_ovf = 0, m_mode = 0;
  logic [7:0] q [$];
  logic [7:0] r;

  always #4 clk = ~clk;

  always_comb ret = pressed[scan_o[2:0]];

  kbd_scan_encoder uut (
    .clk_i(clk), .rst_ni(rst_ni), .ret_i(ret), .shift_i(shift), .ctrl_i(ctrl),
    .scan_o(scan_o), .cs_i(cs), .rd_i(rd), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_o), .irq_o(irq_o));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_step(input bit c_s, input bit r_d, input bit w_r, input bit a, input logic [7:0] wd);
    int rw = slot / 8;
    int cl = slot % 8;
    bit closed = pressed[rw][cl];
    bit any_held = 0;
    bit acc = 0;
    bit full = (q.size() == 8);
    for (int i = 0; i < 64; i++) if (m_held[i]) any_held = 1;
    if (!closed) begin
      m_seen[slot] = 0;
      m_held[slot] = 0;
    end else begin
      if (m_seen[slot] && !m_held[slot] && (m_mode || !any_held)) begin
        acc = 1;
        m_held[slot] = 1;
      end
      m_seen[slot] = 1;
    end
    if (c_s && r_d && !a && q.size() > 0) void'(q.pop_front());
    if (acc && !full) q.push_back({ctrl, shift, 3'(rw), 3'(cl)});
    if (c_s && r_d && a) m_ovf = 0;
    if (acc && full) m_ovf = 1;
    if (c_s && w_r && a) m_mode = wd[0];
    slot = (slot + 1) % 64;
  endtask

  task automatic cyc(input bit c_s, input bit r_d, input bit w_r, input bit a,
                     input logic [7:0] wd, output logic [7:0] res);
    logic [7:0] exp;
    @(negedge clk);
    chk("R1 scan row", {4'b0, scan_o}, 8'(slot / 8));
    chk("R10 irq", {7'b0, irq_o}, {7'b0, q.size() != 0});
    cs = c_s; rd = r_d; wr = w_r; addr = a; wdata = wd;
    #1;
    res = rdata_o;
    if (c_s && r_d) begin
      if (a) begin
        exp = {m_ovf, m_mode, 2'b00, 4'(q.size())};
        chk("R8 status", res, exp);
      end else begin
        exp = (q.size() > 0) ? q[0] : 8'h00;
        chk("R7 data", res, exp);
      end
    end
    model_step(c_s, r_d, w_r, a, wd);
  endtask

  task automatic idle(input int n);
    logic [7:0] x;
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, x);
  endtask

  task automatic rd_stat(output logic [7:0] v);
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, v);
  endtask

  task automatic rd_data(output logic [7:0] v);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, v);
  endtask

  task automatic sync_row0;
    while (slot != 63) idle(1);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) pressed[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    // R11 reset state
    chk("R11 scan", {4'b0, scan_o}, 8'h00);
    chk("R11 irq", {7'b0, irq_o}, 8'h00);
    rd_stat(r); chk("R11 status", r, 8'h00);
    rd_data(r); chk("R7 empty read", r, 8'h00);
    idle(80);

    // R2/R4: single key with shift
    shift = 1'b1;
    pressed[2][5] = 1'b1;
    idle(200);
    rd_stat(r); chk("R2 one code", r, 8'h01);
    rd_data(r); chk("R4 code", r, 8'h55);
    idle(200);
    rd_stat(r); chk("R3 no repeat", r, 8'h00);
    pressed[2][5] = 1'b0;
    idle(70);
    shift = 1'b0;
    pressed[2][5] = 1'b1;
    idle(200);
    rd_data(r); chk("R3 reaccept", r, 8'h15);
    pressed[2][5] = 1'b0;
    idle(70);

    // R5 lockout
    pressed[1][3] = 1'b1;
    idle(140);
    pressed[4][6] = 1'b1;
    idle(200);
    rd_stat(r); chk("R5 first wins", r, 8'h01);
    pressed[1][3] = 1'b0;
    idle(200);
    rd_stat(r); chk("R5 after release", r, 8'h02);
    rd_data(r); chk("R5 first code", r, 8'h0B);
    rd_data(r); chk("R5 second code", r, 8'h26);
    pressed[4][6] = 1'b0;
    idle(70);

    // R6 rollover
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 8'h01, r);
    sync_row0();
    pressed[0][1] = 1'b1; pressed[0][6] = 1'b1; pressed[3][2] = 1'b1;
    idle(200);
    rd_stat(r); chk("R6 count", r, 8'h43);
    rd_data(r); chk("R6 order a", r, 8'h01);
    rd_data(r); chk("R6 order b", r, 8'h06);
    rd_data(r); chk("R6 order c", r, 8'h1A);
    for (int i = 0; i < 8; i++) pressed[i] = 8'h00;
    idle(70);

    // R9 overflow
    pressed[5] = 8'hFF;
    pressed[6] = 8'h03;
    idle(200);
    rd_stat(r); chk("R9 overflow", r, 8'hC8);
    rd_stat(r); chk("R8 clear on read", r, 8'h48);

    // R12 deselected strobes
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, r);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, r);
    rd_stat(r); chk("R12 ignored", r, 8'h48);

    for (int i = 0; i < 8; i++) rd_data(r);
    rd_stat(r); chk("R7 drained", r, 8'h40);
    chk("R10 irq low", {7'b0, irq_o}, 8'h00);
    for (int i = 0; i < 8; i++) pressed[i] = 8'h00;
    idle(140);
    rd_stat(r); chk("R3 no spurious", r, 8'h40);

    summary();
    $finish;
  end
endmodule